// File: doc/BRIEF.md
# Strobed Serial Channel Port

This block carries 16-bit channel words between a codec core and an external host over two framed serial paths. The receive path takes words from the host, and the transmit path sends words to it. Each path has a serial clock, a strobe and a data line. A word moves after a falling edge of its strobe, most significant bit first, on rising edges of the serial clock. On the core side, received words appear on a parallel bus with a one-cycle valid pulse. A word to send is written into a one-word buffer with a load pulse.

In passive mode the host drives both serial clocks and both strobes. The block brings these pins into its system clock domain through two-flop synchronisers and finds their edges there. In active mode the block makes its own serial clock at half the system clock and uses it for both paths. It also makes a sync strobe, and that strobe serves as the strobe of both paths. A free-running frame counter marks each frame. On every frame mark, two flags go up: frame-ready (a word is waiting to be read) and frame-empty (a word can be written). In active mode the same mark also starts a burst of sync pulses.

Top module: `chan_serial_port`

## Requirements
- R1: Each transfer moves WORD_W (16) bits MSB first. After the last receive bit is captured, the assembled word appears on `rx_word` at the same clock edge that raises `rx_valid`, and `rx_valid` is high for exactly one cycle.
- R2: In passive mode the first rising edge of the receive serial clock after a strobe falling edge is skipped. The MSB is taken on the second rising edge and the other bits on the rising edges after it.
- R3: In active mode the receive path takes the MSB on the first rising edge of the internal serial clock after the sync strobe falls. It reads `si_dat` at the system clock edge where `ser_clk` goes from 0 to 1, and it ignores `si_clk`, `si_strb`, `so_clk` and `so_strb`.
- R4: The transmit path loads the buffered word at a strobe falling edge. It then drives one bit on `so_dat` at each of the next 16 rising edges of the transmit serial clock, MSB first. `so_dat` changes at no other time.
- R5: `in_full` is 0 after reset. It goes to 1 when a receive strobe falling edge is acted on, and returns to 0 at the edge that raises `rx_valid`.
- R6: `out_empty` is 1 after reset, goes to 0 on `tx_load`, and goes to 1 when a transmit strobe falling edge is acted on. If a load and a falling edge are acted on at the same edge, the flag goes to 0, the word already in the buffer is the one shifted out, and the newly loaded word waits for the next strobe.
- R7: In active mode `ser_clk` toggles on every system clock edge, so it runs at half the system clock. In passive mode `ser_clk` and `ser_sync` stay at 0.
- R8: In active mode each frame mark starts a burst at the next rising edge of `ser_clk`. The burst has SYNC_PULSES (17) sync pulses, and their rising edges are SLOT_CLKS (64) serial clocks apart. Each pulse is high for one serial clock period (two system clocks).
- R9: A frame mark occurs every FRAME_CYC system clocks and sets both `frm_ready` and `frm_empty`. A transmit strobe falling edge clears `frm_ready`, and a receive strobe falling edge clears `frm_empty`. When a mark and a falling edge land on the same edge, the mark wins.
- R10: In passive mode, a pin level that is present at system clock edge k takes effect in the registered outputs at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_mode | input | 1 | 1 = block makes the serial clock and sync; 0 = host drives them |
| si_clk | input | 1 | Receive serial clock from host (passive mode) |
| si_strb | input | 1 | Receive strobe from host (passive mode) |
| si_dat | input | 1 | Receive serial data |
| so_clk | input | 1 | Transmit serial clock from host (passive mode) |
| so_strb | input | 1 | Transmit strobe from host (passive mode) |
| so_dat | output | 1 | Transmit serial data |
| ser_clk | output | 1 | Generated serial clock (active mode) |
| ser_sync | output | 1 | Generated sync strobe (active mode) |
| in_full | output | 1 | Receive word in progress, port busy |
| out_empty | output | 1 | Transmit buffer has been read and needs a new word |
| frm_ready | output | 1 | Per-frame flag: a word is waiting to be read |
| frm_empty | output | 1 | Per-frame flag: a word can be written |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |
| tx_word | input | WORD_W | Word to transmit |
| tx_load | input | 1 | Load pulse for `tx_word` |

## Verification
A bad bit counter or skip flag shows up as a `rx_word` rotated by one place, or a `so_dat` stream shifted by one bit. The fault is visible at the first `rx_valid`, or at the first transmit rising edge after a strobe. A flag that sets or clears on the wrong event differs on `in_full`, `out_empty`, `frm_ready` or `frm_empty` within two cycles of the strobe event that should have moved it. Slot or pulse counters that drift change the spacing or count of `ser_sync` pulses by the end of the first burst. A wrong synchroniser depth moves every passive response by a whole cycle. The bench's model compares all outputs on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/chan_serial_port.sv
module chan_serial_port #(
  parameter int WORD_W      = 16,
  parameter int FRAME_CYC   = 400000,
  parameter int SYNC_PULSES = 17,
  parameter int SLOT_CLKS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_mode,
  input  logic              si_clk,
  input  logic              si_strb,
  input  logic              si_dat,
  input  logic              so_clk,
  input  logic              so_strb,
  output logic              so_dat,
  output logic              ser_clk,
  output logic              ser_sync,
  output logic              in_full,
  output logic              out_empty,
  output logic              frm_ready,
  output logic              frm_empty,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_load
);
  localparam int CW = $clog2(WORD_W);
  localparam int FW = $clog2(FRAME_CYC);
  localparam int PW = $clog2(SYNC_PULSES);
  localparam int SW = $clog2(SLOT_CLKS);

  logic [2:0]        ick, isb, ock, osb;
  logic [1:0]        idt;
  logic              sync_d, b_pend, b_on;
  logic [PW-1:0]     slot;
  logic [SW-1:0]     bitc;
  logic [FW-1:0]     fcnt;
  logic              i_busy, i_skip, o_busy;
  logic [CW-1:0]     i_cnt, o_cnt;
  logic [WORD_W-1:0] i_sh, o_sh, tx_buf;
  logic              a_rise, i_rise, o_rise, i_fall, o_fall, i_bit, tick;

  assign a_rise = active_mode & ~ser_clk;
  assign i_rise = active_mode ? a_rise : (ick[1] & ~ick[2]);
  assign o_rise = active_mode ? a_rise : (ock[1] & ~ock[2]);
  assign i_fall = active_mode ? (sync_d & ~ser_sync) : (isb[2] & ~isb[1]);
  assign o_fall = active_mode ? (sync_d & ~ser_sync) : (osb[2] & ~osb[1]);
  assign i_bit  = active_mode ? si_dat : idt[1];
  assign tick   = fcnt == FW'(FRAME_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ick <= '0; isb <= '0; ock <= '0; osb <= '0; idt <= '0;
      ser_clk <= 1'b0; sync_d <= 1'b0; fcnt <= '0;
    end else begin
      ick <= {ick[1:0], si_clk};
      isb <= {isb[1:0], si_strb};
      ock <= {ock[1:0], so_clk};
      osb <= {osb[1:0], so_strb};
      idt <= {idt[0], si_dat};
      ser_clk <= active_mode ? ~ser_clk : 1'b0;
      sync_d <= ser_sync;
      fcnt <= tick ? '0 : fcnt + 1'b1;
    end
  end

  // active-mode sync burst, stepped on serial clock rising edges
  always_ff @(posedge clk) begin
    if (!rst_n || !active_mode) begin
      b_pend <= 1'b0; b_on <= 1'b0; slot <= '0; bitc <= '0; ser_sync <= 1'b0;
    end else begin
      if (tick) b_pend <= 1'b1;
      else if (a_rise) b_pend <= 1'b0;
      if (a_rise) begin
        if (b_pend) begin
          b_on <= 1'b1; slot <= '0; bitc <= '0; ser_sync <= 1'b1;
        end else if (b_on) begin
          if (bitc == SW'(SLOT_CLKS - 1)) begin
            bitc <= '0;
            if (slot == PW'(SYNC_PULSES - 1)) begin
              b_on <= 1'b0; ser_sync <= 1'b0;
            end else begin
              slot <= slot + 1'b1; ser_sync <= 1'b1;
            end
          end else begin
            bitc <= bitc + 1'b1; ser_sync <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_busy <= 1'b0; i_skip <= 1'b0; i_cnt <= '0; i_sh <= '0;
      rx_word <= '0; rx_valid <= 1'b0; in_full <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (i_fall) begin
        i_busy <= 1'b1; i_skip <= ~active_mode; i_cnt <= '0; in_full <= 1'b1;
      end else if (i_busy && i_rise) begin
        if (i_skip) i_skip <= 1'b0;
        else begin
          i_sh  <= {i_sh[WORD_W-2:0], i_bit};
          i_cnt <= i_cnt + 1'b1;
          if (i_cnt == CW'(WORD_W - 1)) begin
            i_busy <= 1'b0; in_full <= 1'b0; rx_valid <= 1'b1;
            rx_word <= {i_sh[WORD_W-2:0], i_bit};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_busy <= 1'b0; o_cnt <= '0; o_sh <= '0; so_dat <= 1'b0;
      tx_buf <= '0; out_empty <= 1'b1;
    end else begin
      if (o_fall) begin
        o_busy <= 1'b1; o_cnt <= '0; o_sh <= tx_buf;
      end else if (o_busy && o_rise) begin
        so_dat <= o_sh[WORD_W-1];
        o_sh   <= o_sh << 1;
        o_cnt  <= o_cnt + 1'b1;
        if (o_cnt == CW'(WORD_W - 1)) o_busy <= 1'b0;
      end
      if (tx_load) begin
        tx_buf <= tx_word; out_empty <= 1'b0;
      end else if (o_fall) out_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_ready <= 1'b0; frm_empty <= 1'b0;
    end else if (tick) begin
      frm_ready <= 1'b1; frm_empty <= 1'b1;
    end else begin
      if (o_fall) frm_ready <= 1'b0;
      if (i_fall) frm_empty <= 1'b0;
    end
  end

  a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r5_full_drops_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !in_full);
  a_r6_load_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !out_empty);
  a_r4_data_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !o_rise |=> $stable(so_dat));
  a_r7_quiet_when_passive: assert property (@(posedge clk) disable iff (!rst_n)
    !active_mode |=> (!ser_clk && !ser_sync));
  a_r8_sync_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_sync) |=> ser_sync ##1 !ser_sync);
  a_r9_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fall && !tick) |=> !frm_ready);
endmodule

// File: tb/chan_serial_port_test.sv
module chan_serial_port_test;
  localparam int W = 16;
  localparam int FRAME = 3000;

  logic clk = 1'b0, rst_n = 1'b0, active_mode = 1'b0;
  logic si_clk = 0, si_strb = 0, si_dat = 0, so_clk = 0, so_strb = 0;
  logic so_dat, ser_clk, ser_sync, in_full, out_empty, frm_ready, frm_empty, rx_valid;
  logic [W-1:0] rx_word;
  logic [W-1:0] tx_word = '0;
  logic tx_load = 1'b0;

  chan_serial_port #(.WORD_W(W), .FRAME_CYC(FRAME)) uut (
    .clk(clk), .rst_n(rst_n), .active_mode(active_mode),
    .si_clk(si_clk), .si_strb(si_strb), .si_dat(si_dat),
    .so_clk(so_clk), .so_strb(so_strb), .so_dat(so_dat),
    .ser_clk(ser_clk), .ser_sync(ser_sync), .in_full(in_full), .out_empty(out_empty),
    .frm_ready(frm_ready), .frm_empty(frm_empty), .rx_word(rx_word), .rx_valid(rx_valid),
    .tx_word(tx_word), .tx_load(tx_load));

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0;
  bit run = 0, done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  logic [2:0] h_ic = 0, h_is = 0, h_oc = 0, h_os = 0;
  logic [1:0] h_id = 0;
  bit m_sclk = 0, m_sync = 0, m_sync_p = 0, pend = 0;
  int bpos = -1, fc = 0;
  bit ibusy = 0, iskip = 0;
  bit ibits[$];
  bit oq[$];
  logic [W-1:0] m_rxw = 0, m_obuf = 0;
  bit m_rxv = 0, m_full = 0, m_empty = 1, m_fr = 0, m_fe = 0, m_sd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_ic = 0; h_is = 0; h_oc = 0; h_os = 0; h_id = 0;
      m_sclk = 0; m_sync = 0; m_sync_p = 0; pend = 0; bpos = -1; fc = 0;
      ibusy = 0; iskip = 0; ibits.delete(); oq.delete();
      m_rxw = 0; m_obuf = 0; m_rxv = 0; m_full = 0; m_empty = 1; m_fr = 0; m_fe = 0; m_sd = 0;
    end else begin
      bit act, arise, irise, orise, ifall, ofall, ibit, tick;
      act   = active_mode;
      arise = act && !m_sclk;
      irise = act ? arise : (h_ic[1] && !h_ic[2]);
      orise = act ? arise : (h_oc[1] && !h_oc[2]);
      ifall = act ? (m_sync_p && !m_sync) : (h_is[2] && !h_is[1]);
      ofall = act ? (m_sync_p && !m_sync) : (h_os[2] && !h_os[1]);
      ibit  = act ? si_dat : h_id[1];
      tick  = (fc == FRAME - 1);
      m_rxv = 0;
      if (ifall) begin
        ibusy = 1; iskip = !act; ibits.delete(); m_full = 1;
      end else if (ibusy && irise) begin
        if (iskip) iskip = 0;
        else begin
          ibits.push_back(ibit);
          if (ibits.size() == W) begin
            for (int j = 0; j < W; j++) m_rxw[W-1-j] = ibits[j];
            m_rxv = 1; ibusy = 0; m_full = 0;
          end
        end
      end
      if (ofall) begin
        oq.delete();
        for (int j = W - 1; j >= 0; j--) oq.push_back(m_obuf[j]);
      end else if (orise && oq.size() > 0) m_sd = oq.pop_front();
      if (tx_load) begin m_obuf = tx_word; m_empty = 0; end
      else if (ofall) m_empty = 1;
      if (tick) begin m_fr = 1; m_fe = 1; end
      else begin
        if (ofall) m_fr = 0;
        if (ifall) m_fe = 0;
      end
      m_sync_p = m_sync;
      if (!act) begin bpos = -1; m_sync = 0; end
      else if (arise) begin
        if (pend) bpos = 0;
        else if (bpos >= 0) begin
          bpos++;
          if (bpos == 17 * 64) bpos = -1;
        end
        m_sync = (bpos >= 0) && (bpos % 64 == 0);
      end
      if (!act) pend = 0;
      else if (tick) pend = 1;
      else if (arise) pend = 0;
      fc = (fc + 1) % FRAME;
      m_sclk = act ? !m_sclk : 0;
      h_ic = {h_ic[1:0], si_clk}; h_is = {h_is[1:0], si_strb};
      h_oc = {h_oc[1:0], so_clk}; h_os = {h_os[1:0], so_strb};
      h_id = {h_id[0], si_dat};
    end
  end

  logic [W-1:0] got[$];
  int nsync = 0;
  logic sync_seen = 0;

  always @(negedge clk) begin
    if (run) begin
      chk(rx_valid == m_rxv, "R1 rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_word == m_rxw, "R1 rx_word", rx_word, m_rxw);
      chk(in_full == m_full, "R5 in_full", in_full, m_full);
      chk(out_empty == m_empty, "R6 out_empty", out_empty, m_empty);
      chk(frm_ready == m_fr, "R9 frm_ready", frm_ready, m_fr);
      chk(frm_empty == m_fe, "R9 frm_empty", frm_empty, m_fe);
      chk(so_dat == m_sd, "R4 so_dat", so_dat, m_sd);
      chk(ser_clk == m_sclk, "R7 ser_clk", ser_clk, m_sclk);
      chk(ser_sync == m_sync, "R8 ser_sync", ser_sync, m_sync);
      if (rx_valid) got.push_back(rx_word);
      if (ser_sync && !sync_seen) nsync++;
      sync_seen = ser_sync;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_in(input logic [W-1:0] w);
    si_strb = 1; cyc(6); si_strb = 0;
    cyc(2); chk(in_full == 0, "R10 in_full before k+2", in_full, 0);
    cyc(1); chk(in_full == 1, "R10 in_full at k+2", in_full, 1);
    for (int k = 0; k <= W; k++) begin
      si_dat = (k == 0) ? ~w[W-1] : w[W-k];
      cyc(3); si_clk = 1; cyc(3); si_clk = 0;
    end
    cyc(4);
  endtask

  task automatic read_bits(output logic [W-1:0] w);
    for (int k = 0; k < W; k++) begin
      so_clk = 1; cyc(3); w[W-1-k] = so_dat; so_clk = 0; cyc(3);
    end
  endtask

  task automatic read_out(output logic [W-1:0] w);
    so_strb = 1; cyc(6); so_strb = 0; cyc(3);
    read_bits(w);
  endtask

  task automatic load(input logic [W-1:0] w);
    tx_word = w; tx_load = 1; cyc(1); tx_load = 0;
  endtask

  task automatic expect_rx(input logic [W-1:0] w, input string req);
    if (got.size() == 0) chk(0, req, 0, w);
    else begin
      logic [W-1:0] g;
      g = got.pop_front();
      chk(g == w, req, g, w);
    end
  endtask

  initial begin
    logic [W-1:0] r;
    int guard;
    cyc(4); rst_n = 1; run = 1;
    cyc(1);
    chk(in_full == 0 && rx_valid == 0, "R5 reset in_full", in_full, 0);
    chk(out_empty == 1, "R6 reset out_empty", out_empty, 1);
    chk(ser_clk == 0 && ser_sync == 0, "R7 passive quiet", {ser_clk, ser_sync}, 0);
    chk(frm_ready == 0 && frm_empty == 0, "R9 reset frame flags", {frm_ready, frm_empty}, 0);

    load(16'hA5C3);
    chk(out_empty == 0, "R6 load clears", out_empty, 0);
    send_in(16'h8001); expect_rx(16'h8001, "R2 passive skip first edge");
    send_in(16'h7FFE); expect_rx(16'h7FFE, "R2 passive word");
    send_in(16'h1234); expect_rx(16'h1234, "R1 passive word");
    read_out(r);
    chk(r == 16'hA5C3, "R4 shifted word", r, 16'hA5C3);
    chk(out_empty == 1, "R6 set by strobe", out_empty, 1);

    load(16'h3C5A);
    so_strb = 1; cyc(6); so_strb = 0; cyc(2);
    tx_word = 16'hF00F; tx_load = 1; cyc(1); tx_load = 0;
    chk(out_empty == 0, "R6 load beats strobe", out_empty, 0);
    cyc(2); read_bits(r);
    chk(r == 16'h3C5A, "R6 old word shifted", r, 16'h3C5A);
    read_out(r);
    chk(r == 16'hF00F, "R6 new word kept", r, 16'hF00F);

    guard = 0;
    while (!frm_ready && guard < 4000) begin cyc(1); guard++; end
    chk(frm_ready == 1 && frm_empty == 1, "R9 frame mark", {frm_ready, frm_empty}, 2'b11);
    read_out(r);
    chk(frm_ready == 0 && frm_empty == 1, "R9 read clears ready only", {frm_ready, frm_empty}, 2'b01);
    send_in(16'h0F0F); expect_rx(16'h0F0F, "R1 word after mark");
    chk(frm_empty == 0, "R9 write clears empty", frm_empty, 0);

    // active mode
    run = 0; rst_n = 0; active_mode = 1; cyc(4);
    got.delete(); nsync = 0; sync_seen = 0;
    rst_n = 1; run = 1;
    begin
      logic [W-1:0] sent[$];
      logic [W-1:0] cw;
      logic sp;
      int ib;
      sp = 0; ib = 0; cw = 16'h1357;
      for (int t = 0; t < 5600; t++) begin
        @(negedge clk);
        tx_load = 0;
        if (t % 5 == 0) si_strb = ~si_strb;
        if (t % 3 == 0) si_clk = ~si_clk;
        if (t % 7 == 0) so_strb = ~so_strb;
        if (t % 4 == 0) so_clk = ~so_clk;
        if (sp && !ser_sync) begin
          cw = cw * 16'd13 + 16'h2B1;
          sent.push_back(cw); ib = W;
        end
        sp = ser_sync;
        if (ib > 0 && !ser_clk) begin si_dat = cw[ib-1]; ib--; end
        if (out_empty) begin tx_word = cw ^ 16'h5A5A; tx_load = 1; end
      end
      @(negedge clk); tx_load = 0;
      chk(nsync == 17, "R8 sync pulses per burst", nsync, 17);
      chk(got.size() == sent.size() && sent.size() == 17, "R3 active word count", got.size(), sent.size());
      for (int i = 0; i < sent.size(); i++)
        expect_rx(sent[i], "R3 active capture");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule